// File: doc/BRIEF.md
# Banked Language Card Controller

This controller manages a 16K RAM expansion that sits over the ROM in the top 12K of a 16-bit address space (0xD000-0xFFFF). The 0xD000-0xDFFF window holds two 4K RAM banks that can be swapped. Accesses to the sixteen control addresses 0xC080-0xC08F set three things: whether reads come from RAM, whether writes are accepted, and which bank is selected. Writing is guarded by a pre-write flip-flop. Two read accesses in a row to an odd control address are needed before writes are accepted.

For each access, the block gives combinational steering for the RAM arrays and ROM outside it:
- whether the 0xD000-0xFFFF range is hit;
- whether the read data should come from RAM or ROM;
- whether the bank-2 area is addressed;
- whether the aux card RAM is used in place of the main card RAM;
- whether a write may land.

Two status addresses return the bank and read-enable state in bit 7. The state registers change on the clock edge that ends an access.

Top module: `lcard_ctrl`

## Requirements
- R1: After reset, writes are enabled, reads come from ROM, bank 2 is selected and the pre-write flip-flop is clear.
- R2: Within 0xC080-0xC08F, address bit 2 is ignored, so 0xC084-0xC087 and 0xC08C-0xC08F behave exactly like 0xC080-0xC083 and 0xC088-0xC08B.
- R3: A control access with address bit 3 = 0 selects bank 2; with bit 3 = 1 it selects bank 1.
- R4: A control access whose low two address bits are 00 or 11 enables RAM reads; 01 or 10 disables them.
- R5: A control access with address bit 0 = 0 clears both write enable and the pre-write flip-flop.
- R6: A control access with address bit 0 = 1 ORs the previous pre-write value into write enable, then loads pre-write with 1 on a read and 0 on a write. Two successive odd reads therefore enable writing.
- R7: In 0xD000-0xDFFF, `ram_bank2` is 1 when bank 2 is selected and 0 when bank 1 is selected. In 0xE000-0xFFFF, `ram_bank2` is always 0.
- R8: `ram_aux` follows `alt_zp` for accesses in 0xD000-0xFFFF and is 0 outside that range.
- R9: `rd_ram` is 1 only for a read in 0xD000-0xFFFF while RAM reads are enabled; otherwise ROM supplies the data. `wr_ok` is 1 only for a write in that range while writes are enabled; otherwise the write is dropped.
- R10: A read of 0xC011 gives `stat_data` = 0x80 when bank 2 is selected, and a read of 0xC012 gives 0x80 when RAM reads are enabled. Each gives 0x00 otherwise, and `stat_hit` marks these reads.
- R11: An access outside 0xC080-0xC08F leaves the bank, read-enable, write-enable and pre-write state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | 16 | Access address |
| acc_we | input | 1 | 1 for a write access, 0 for a read |
| alt_zp | input | 1 | External flag selecting aux card RAM |
| lc_hit | output | 1 | Access falls in 0xD000-0xFFFF |
| rd_ram | output | 1 | Read data comes from RAM rather than ROM |
| ram_bank2 | output | 1 | RAM access targets the bank-2 area |
| ram_aux | output | 1 | RAM access targets the aux card |
| wr_ok | output | 1 | Write to RAM is allowed |
| stat_hit | output | 1 | Access is a status read |
| stat_data | output | 8 | Status byte |

## Verification
The assertions assume that every access lasts exactly one valid cycle. They also assume that `acc_we` and `acc_addr` are stable during that cycle, since a state update is taken from the values present at the clock edge.

The stimulus drives all inputs on the falling edge and holds them through the next rising edge. Between accesses it drops `acc_valid`. It probes the state with read accesses to the overlay and status ranges; under R11 these reads must not disturb the state.

// File: rtl/lcard_ctrl.sv
module lcard_ctrl #(
  parameter int AW = 16,
  parameter logic [AW-1:0] CTRL_BASE = 16'hC080,
  parameter logic [AW-1:0] STAT_BANK = 16'hC011,
  parameter logic [AW-1:0] STAT_RD   = 16'hC012
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_we,
  input  logic          alt_zp,
  output logic          lc_hit,
  output logic          rd_ram,
  output logic          ram_bank2,
  output logic          ram_aux,
  output logic          wr_ok,
  output logic          stat_hit,
  output logic [7:0]    stat_data
);
  localparam int TOP = AW - 1;

  logic rd_en_q, wr_en_q, bank2_q, pre_q;
  logic ctrl_hit, odd_sel;

  assign ctrl_hit = acc_valid && (acc_addr[TOP:4] == CTRL_BASE[TOP:4]);
  assign odd_sel  = acc_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b1;
      bank2_q <= 1'b1;
      pre_q   <= 1'b0;
    end else if (ctrl_hit) begin
      bank2_q <= ~acc_addr[3];
      rd_en_q <= ~(acc_addr[1] ^ acc_addr[0]);
      if (odd_sel) begin
        wr_en_q <= wr_en_q | pre_q;
        pre_q   <= ~acc_we;
      end else begin
        wr_en_q <= 1'b0;
        pre_q   <= 1'b0;
      end
    end
  end

  assign lc_hit    = acc_valid && (acc_addr[TOP:TOP-3] >= 4'hD);
  assign rd_ram    = lc_hit && !acc_we && rd_en_q;
  assign wr_ok     = lc_hit && acc_we && wr_en_q;
  assign ram_bank2 = lc_hit && (acc_addr[TOP:TOP-3] == 4'hD) && bank2_q;
  assign ram_aux   = lc_hit && alt_zp;

  logic st_bank, st_rd;
  assign st_bank   = acc_valid && !acc_we && (acc_addr == STAT_BANK);
  assign st_rd     = acc_valid && !acc_we && (acc_addr == STAT_RD);
  assign stat_hit  = st_bank || st_rd;
  assign stat_data = {(st_bank && bank2_q) || (st_rd && rd_en_q), 7'b0};
endmodule

// File: rtl/lcard_ctrl_chk.sv
module lcard_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [15:0] acc_addr,
  input logic        acc_we,
  input logic        rd_en_q,
  input logic        wr_en_q,
  input logic        bank2_q,
  input logic        pre_q
);
  logic is_ctrl;
  assign is_ctrl = acc_valid && (acc_addr[15:4] == 12'hC08);

  // R5
  even_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl && !acc_addr[0] |=> !wr_en_q && !pre_q);
  // R6
  odd_write_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl && acc_addr[0] && acc_we |=> !pre_q);
  // R6
  two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl && acc_addr[0] && !acc_we && pre_q |=> wr_en_q && pre_q);
  // R3
  bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl && acc_addr[3] |=> !bank2_q);
  // R4
  rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl && (acc_addr[1:0] == 2'b01) |=> !rd_en_q);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ctrl |=> $stable({rd_en_q, wr_en_q, bank2_q, pre_q}));
endmodule

bind lcard_ctrl lcard_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_we(acc_we), .rd_en_q(rd_en_q), .wr_en_q(wr_en_q),
  .bank2_q(bank2_q), .pre_q(pre_q)
);

// File: tb/tb_lcard_ctrl.sv
module tb_lcard_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_we = 1'b0, alt_zp = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic lc_hit, rd_ram, ram_bank2, ram_aux, wr_ok, stat_hit;
  logic [7:0] stat_data;
  int checks = 0, errors = 0;
  bit m_rd, m_wr, m_b2, m_pre;

  always #10 clk = ~clk;

  lcard_ctrl dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input bit we);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_we = we;
    @(posedge clk);
    if (a[15:4] == 12'hC08) begin
      m_b2 = ~a[3];
      m_rd = ~(a[1] ^ a[0]);
      if (a[0]) begin m_wr = m_wr | m_pre; m_pre = ~we; end
      else begin m_wr = 1'b0; m_pre = 1'b0; end
    end
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic look(input logic [15:0] a, input bit we);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_we = we;
    #2;
  endtask

  task automatic probe(input string req);
    look(16'hD123, 1'b0);
    chk(rd_ram == m_rd, {req, " rd_ram"}, rd_ram, m_rd);
    chk(ram_bank2 == m_b2, {req, " ram_bank2"}, ram_bank2, m_b2);
    look(16'hD123, 1'b1);
    chk(wr_ok == m_wr, {req, " wr_ok"}, wr_ok, m_wr);
    look(16'hC011, 1'b0);
    chk(stat_data == (m_b2 ? 8'h80 : 8'h00), {req, " R10 bank status"}, stat_data, m_b2 ? 8'h80 : 8'h00);
    look(16'hC012, 1'b0);
    chk(stat_data == (m_rd ? 8'h80 : 8'h00), {req, " R10 read status"}, stat_data, m_rd ? 8'h80 : 8'h00);
    @(negedge clk); acc_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    m_rd = 0; m_wr = 1; m_b2 = 1; m_pre = 0;
    probe("R1");
    // R6: a single odd read arms pre-write but must not set write enable
    access(16'hC080, 0);
    access(16'hC081, 0);
    probe("R6 single read");
    access(16'hC081, 0);
    probe("R6 double read");
    // R5, R6, R3, R4, R2: sweep ordered pairs of control accesses
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          access(16'hC080 + 16'(i), w[0]);
          access(16'hC080 + 16'(j), w[1]);
          probe("R2 R3 R4 R5 R6 sweep");
        end
    // R11: accesses outside the control range
    access(16'hC083, 0); access(16'hC083, 0);
    access(16'hC07F, 0); access(16'hC090, 1); access(16'hC08B - 16'h1000, 0);
    access(16'hD000, 1); access(16'hC011, 0);
    probe("R11");
    // R7: upper area has no bank-2 routing
    look(16'hE456, 1'b0);
    chk(ram_bank2 == 1'b0, "R7 upper area", ram_bank2, 0);
    chk(lc_hit == 1'b1, "R7 hit", lc_hit, 1);
    access(16'hC08B, 0);
    look(16'hD000, 1'b0);
    chk(ram_bank2 == 1'b0, "R7 bank1 lower", ram_bank2, 0);
    // R8
    for (int z = 0; z < 2; z++) begin
      alt_zp = z[0];
      look(16'hF000, 1'b0);
      chk(ram_aux == z[0], "R8 overlay", ram_aux, z);
      look(16'h8000, 1'b0);
      chk(ram_aux == 1'b0, "R8 outside", ram_aux, 0);
      chk(lc_hit == 1'b0, "R9 outside hit", lc_hit, 0);
    end
    // R9: read disabled gives ROM, write disabled drops
    access(16'hC08A, 0);
    look(16'hFFFF, 1'b0);
    chk(rd_ram == 1'b0, "R9 rom read", rd_ram, 0);
    look(16'hFFFF, 1'b1);
    chk(wr_ok == 1'b0, "R9 write dropped", wr_ok, 0);
    look(16'hC011, 1'b1);
    chk(stat_hit == 1'b0, "R10 write is not status", stat_hit, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule